// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Arbiter

This block arbitrates among a row of interrupt sources that share a single request line and a single vector bus. Each source owns one slice of a chain. A slice turns a rising edge on its device request into a pending flag. The shared request line goes high whenever any slice has a pending flag. When the processor answers with an acknowledge, the acknowledge enters slice 0, the slice nearest the processor, and passes from slice to slice. A slice with nothing pending passes it on without a clock. The first slice that holds a pending flag keeps the acknowledge and stops it from going further. That slice then drives the value of its programmable vector register onto the bus. Priority therefore follows position alone, and no central encoder is needed.

The acknowledge is a level that the processor may hold for one or more cycles. Arbitration stays frozen while it is held. Requests that rise during the acknowledge are parked and join only after the acknowledge ends. When the acknowledge drops, the winning slice clears its pending flag at that clock edge. Each slice's bus driver is modelled as an enable plus a gated value, and the gated values are merged onto one bus. The per-slice enables come out as a port so that bus ownership can be observed. The block contains a two-flop reset synchronizer: reset asserts at once and releases on the clock.

Top module: `irq_daisy_chain`

## Requirements
- R1: `irq_line` is high exactly while at least one slice holds a pending request. While `cpu_ack` and `irq_line` are both high, some slice drives the bus.
- R2: While `cpu_ack` is high, the lowest-indexed slice with a pending request asserts its bit of `bus_drv` (bit i belongs to slice i), and `bus_data` equals that slice's vector register.
- R3: Slices past the responder never see the acknowledge. `ack_tail` is high only when `cpu_ack` is high and no slice is pending, and in that case no slice drives the bus.
- R4: At most one bit of `bus_drv` is high. All bits are low while `cpu_ack` is low. `bus_data` is zero whenever no slice drives.
- R5: At the first clock edge where `cpu_ack` is sampled low after an acknowledge, only the responding slice clears its pending request. The other pending requests remain.
- R6: A request edge that arrives while `cpu_ack` is high takes no part in the current acknowledge and does not alter pending state. It becomes pending at the first clock edge where `cpu_ack` is sampled low.
- R7: A clock edge with `vec_wr_en[i]` high loads `vec_wr_data` into slice i's vector register. Later acknowledges won by slice i return that value.
- R8: Requests are edge-triggered: a 0-to-1 change of `dev_req[i]` sets pending. A level held high after service does not set pending again until a new rising edge.
- R9: After reset no request is pending, every vector register is zero, `irq_line` and `ack_tail` are low, and the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_req | input | N_SLICES | Per-device request; a rising edge raises a request |
| vec_wr_en | input | N_SLICES | Per-slice vector register load enable |
| vec_wr_data | input | VEC_W | Value loaded into the selected vector registers |
| cpu_ack | input | 1 | Acknowledge from the processor, enters slice 0 |
| irq_line | output | 1 | Shared request line, high when any slice is pending |
| bus_data | output | VEC_W | Shared vector bus |
| bus_drv | output | N_SLICES | Driver enable of each slice on the vector bus |
| ack_tail | output | 1 | Acknowledge leaving the last slice, unclaimed |

## Verification
A pending flag that fails to clear shows up at the first clock edge after the acknowledge drops: `irq_line` stays high, and the next acknowledge gives the bus to the stale slice. A flag that sets at the wrong time shows up while `cpu_ack` is still high as a change of `bus_drv` in the middle of an acknowledge. A break in the pass-through chain shows up in the same cycle the acknowledge rises. The symptom is a wrong `bus_drv` bit, two drivers at once, or `ack_tail` being high while a request is pending. A corrupt vector register shows up only when its slice next wins, as a wrong `bus_data` value.

// File: rtl/irq_dc_pkg.sv
package irq_dc_pkg;
  localparam int unsigned DC_SLICES_DEF = 4;
  localparam int unsigned DC_VEC_W_DEF  = 8;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/irq_req_cond.sv
module irq_req_cond #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] dev_req,
  input  logic         cpu_ack,
  input  logic [N-1:0] take,
  output logic [N-1:0] pend,
  output logic [N-1:0] hold
);
  logic [N-1:0] req_q, hold_q, pend_q, win_q;
  logic [N-1:0] req_d, hold_d, pend_d, win_d;
  logic [N-1:0] rise, clr;

  // next-state logic
  always_comb begin
    rise  = dev_req & ~req_q;
    req_d = dev_req;
    clr   = cpu_ack ? '0 : win_q;
    if (cpu_ack) begin
      // arbitration frozen: park new edges, remember the winner
      hold_d = hold_q | rise;
      pend_d = pend_q;
      win_d  = win_q | take;
    end else begin
      hold_d = '0;
      pend_d = (pend_q & ~clr) | hold_q | rise;
      win_d  = '0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      hold_q <= '0;
      pend_q <= '0;
      win_q  <= '0;
    end else begin
      req_q  <= req_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
      win_q  <= win_d;
    end
  end

  assign pend = pend_q;
  assign hold = hold_q;
endmodule

// File: rtl/irq_chain_slice.sv
module irq_chain_slice #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_data,
  input  logic             pend,
  input  logic             ack_in,
  output logic             ack_out,
  output logic             take,
  output logic [VEC_W-1:0] drv_dat
);
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vec_q <= '0;
    else if (wr_en) vec_q <= wr_data;
  end

  // absorb the acknowledge when pending, otherwise pass it on
  always_comb begin
    take    = ack_in & pend;
    ack_out = ack_in & ~pend;
    drv_dat = take ? vec_q : '0;
  end
endmodule

// File: rtl/irq_bus_merge.sv
module irq_bus_merge #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic [N*W-1:0] dat_flat,
  output logic [W-1:0]   bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | dat_flat[i*W +: W];
  end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
  import irq_dc_pkg::*;
#(
  parameter int unsigned N_SLICES = DC_SLICES_DEF,
  parameter int unsigned VEC_W    = DC_VEC_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SLICES-1:0] dev_req,
  input  logic [N_SLICES-1:0] vec_wr_en,
  input  logic [VEC_W-1:0]    vec_wr_data,
  input  logic                cpu_ack,
  output logic                irq_line,
  output logic [VEC_W-1:0]    bus_data,
  output logic [N_SLICES-1:0] bus_drv,
  output logic                ack_tail
);
  localparam int unsigned FLAT_W = N_SLICES * VEC_W;

  logic                rst_s;
  logic [N_SLICES-1:0] pend_v, hold_v, take_v;
  logic [FLAT_W-1:0]   dat_flat;

  irq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s)
  );

  irq_req_cond #(.N(N_SLICES)) u_req (
    .clk     (clk),
    .rst_n   (rst_s),
    .dev_req (dev_req),
    .cpu_ack (cpu_ack),
    .take    (take_v),
    .pend    (pend_v),
    .hold    (hold_v)
  );

  for (genvar i = 0; i < N_SLICES; i++) begin : g_sl
    logic             ack_in_s;
    logic             ack_out_s;
    logic             take_s;
    logic [VEC_W-1:0] dat_s;

    if (i == 0) begin : g_head
      assign ack_in_s = cpu_ack;
    end else begin : g_link
      assign ack_in_s = g_sl[i-1].ack_out_s;
    end

    irq_chain_slice #(.VEC_W(VEC_W)) u_slice (
      .clk     (clk),
      .rst_n   (rst_s),
      .wr_en   (vec_wr_en[i]),
      .wr_data (vec_wr_data),
      .pend    (pend_v[i]),
      .ack_in  (ack_in_s),
      .ack_out (ack_out_s),
      .take    (take_s),
      .drv_dat (dat_s)
    );

    assign take_v[i]                  = take_s;
    assign dat_flat[i*VEC_W +: VEC_W] = dat_s;
  end

  irq_bus_merge #(.N(N_SLICES), .W(VEC_W)) u_merge (
    .dat_flat (dat_flat),
    .bus      (bus_data)
  );

  assign bus_drv  = take_v;
  assign irq_line = |pend_v;
  assign ack_tail = g_sl[N_SLICES-1].ack_out_s;
endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cpu_ack,
  input logic [N-1:0] dev_req,
  input logic [N-1:0] pend,
  input logic [N-1:0] hold,
  input logic [N-1:0] bus_drv,
  input logic [W-1:0] bus_data,
  input logic         ack_tail,
  input logic         irq_line
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  a_r1_ack_served: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && irq_line) |-> (bus_drv != '0));

  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drv != '0) |-> (((pend & (bus_drv - N'(1))) == '0) && ((bus_drv & pend) == bus_drv)));

  a_r3_tail_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ack_tail |-> (cpu_ack && !irq_line && bus_drv == '0));

  a_r4_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_drv));

  a_r4_no_ack_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ack |-> (bus_drv == '0));

  a_r4_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drv == '0) |-> (bus_data == '0));

  a_r6_frozen_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(cpu_ack)) |-> $stable(pend));

  for (genvar i = 0; i < N; i++) begin : g_clr
    a_r5_winner_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && bus_drv[i]) ##1 (!cpu_ack && !hold[i] && !dev_req[i]) |=> !pend[i]);
  end
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(.N(N_SLICES), .W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s),
  .cpu_ack  (cpu_ack),
  .dev_req  (dev_req),
  .pend     (pend_v),
  .hold     (hold_v),
  .bus_drv  (bus_drv),
  .bus_data (bus_data),
  .ack_tail (ack_tail),
  .irq_line (irq_line)
);

// File: tb/irq_daisy_chain_test.sv
module irq_daisy_chain_test;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] dev_req;
  logic [N-1:0] vec_wr_en;
  logic [W-1:0] vec_wr_data;
  logic         cpu_ack;
  logic         irq_line;
  logic [W-1:0] bus_data;
  logic [N-1:0] bus_drv;
  logic         ack_tail;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  irq_daisy_chain #(.N_SLICES(N), .VEC_W(W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_req     (dev_req),
    .vec_wr_en   (vec_wr_en),
    .vec_wr_data (vec_wr_data),
    .cpu_ack     (cpu_ack),
    .irq_line    (irq_line),
    .bus_data    (bus_data),
    .bus_drv     (bus_drv),
    .ack_tail    (ack_tail)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic program_vec(input int idx, input logic [W-1:0] v);
    vec_wr_en        = '0;
    vec_wr_en[idx]   = 1'b1;
    vec_wr_data      = v;
    nclk(1);
    vec_wr_en        = '0;
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    dev_req = m;
    nclk(1);
    dev_req = '0;
  endtask

  task automatic serve(input string req, input logic [N-1:0] exp_drv, input logic [W-1:0] exp_dat);
    cpu_ack = 1'b1;
    #1;
    chk({req, " bus_drv"}, 32'(bus_drv), 32'(exp_drv));
    chk({req, " bus_data"}, 32'(bus_data), 32'(exp_dat));
    chk({req, " ack_tail"}, 32'(ack_tail), 32'(exp_drv == '0));
    nclk(1);
    cpu_ack = 1'b0;
    nclk(1);
  endtask

  task automatic t_reset;
    chk("R9 irq_line", 32'(irq_line), 0);
    chk("R9 bus_drv", 32'(bus_drv), 0);
    chk("R9 bus_data", 32'(bus_data), 0);
    chk("R9 ack_tail", 32'(ack_tail), 0);
  endtask

  task automatic t_single;
    pulse_req(4'b0100);
    chk("R1 irq_line up", 32'(irq_line), 1);
    serve("R2 single", 4'b0100, 8'h33);
    chk("R5 cleared", 32'(irq_line), 0);
  endtask

  task automatic t_priority;
    pulse_req(4'b1010);
    serve("R2 prio first", 4'b0010, 8'h22);
    chk("R5 others remain", 32'(irq_line), 1);
    serve("R3 second", 4'b1000, 8'h44);
    chk("R5 all served", 32'(irq_line), 0);
  endtask

  task automatic t_empty;
    serve("R3 empty chain", 4'b0000, 8'h00);
    chk("R1 empty irq", 32'(irq_line), 0);
  endtask

  task automatic t_no_ack_idle;
    pulse_req(4'b0001);
    chk("R4 idle drv", 32'(bus_drv), 0);
    chk("R4 idle data", 32'(bus_data), 0);
    serve("R2 slice0", 4'b0001, 8'h11);
  endtask

  task automatic t_late;
    pulse_req(4'b1000);
    cpu_ack = 1'b1;
    nclk(1);
    dev_req[0] = 1'b1;
    nclk(1);
    dev_req = '0;
    nclk(1);
    chk("R6 late drv", 32'(bus_drv), 32'(4'b1000));
    chk("R6 late data", 32'(bus_data), 32'h44);
    cpu_ack = 1'b0;
    nclk(1);
    chk("R6 parked joins", 32'(irq_line), 1);
    serve("R6 parked served", 4'b0001, 8'h11);
    chk("R6 done", 32'(irq_line), 0);
  endtask

  task automatic t_level;
    dev_req[1] = 1'b1;
    nclk(1);
    chk("R8 edge sets", 32'(irq_line), 1);
    serve("R8 serve", 4'b0010, 8'h22);
    chk("R8 level ignored", 32'(irq_line), 0);
    nclk(2);
    chk("R8 level still ignored", 32'(irq_line), 0);
    dev_req = '0;
    nclk(1);
    dev_req[1] = 1'b1;
    nclk(1);
    chk("R8 new edge", 32'(irq_line), 1);
    dev_req = '0;
    serve("R8 serve again", 4'b0010, 8'h22);
  endtask

  task automatic t_long_ack;
    pulse_req(4'b0101);
    cpu_ack = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R2 held ack drv", 32'(bus_drv), 32'(4'b0001));
      nclk(1);
    end
    cpu_ack = 1'b0;
    nclk(1);
    serve("R5 remaining", 4'b0100, 8'h33);
    chk("R5 empty", 32'(irq_line), 0);
  endtask

  task automatic t_rewrite;
    program_vec(2, 8'h5A);
    pulse_req(4'b0100);
    serve("R7 rewritten", 4'b0100, 8'h5A);
  endtask

  initial begin
    rst_n       = 1'b0;
    dev_req     = '0;
    vec_wr_en   = '0;
    vec_wr_data = '0;
    cpu_ack     = 1'b0;
    nclk(3);
    rst_n = 1'b1;
    nclk(3);
    t_reset();
    program_vec(0, 8'h11);
    program_vec(1, 8'h22);
    program_vec(2, 8'h33);
    program_vec(3, 8'h44);
    t_single();
    t_priority();
    t_empty();
    t_no_ack_idle();
    t_late();
    t_level();
    t_long_ack();
    t_rewrite();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule